// File: doc/BRIEF.md
# Quaternary Differential Encoder with Serial-to-Parallel Split

This block sits in a spread-spectrum transmit chain between the chip scrambler and the phase selector. It receives a serial chip stream, one bit on each cycle where the chip enable is high. It groups the chips into consecutive pairs. The first chip of a pair becomes the in-phase bit `a` and the second becomes the quadrature bit `b`. Each pair forms an absolute two-bit symbol with value 2a+b.

On a symbol enable that runs at half the chip rate, the block takes the most recently completed pair. It adds that pair modulo 4 to the encoded symbol it produced before. The result is a relative symbol 2c+d, driven from registers together with a one-cycle valid strobe. A downstream phase selector maps the relative symbol onto one of four carrier phases. The phase selector does not need any absolute phase reference.

Top module: `quad_diff_encoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sym_hi`, `sym_lo` and `sym_valid` are 0. The previous encoded symbol is 00. The next enabled chip after reset is taken as the in-phase bit of a new pair, and no pair is pending.
- R2: Enabled chips are paired in arrival order. The first chip of a pair is the high bit `a` of the absolute symbol 2a+b, and the second chip is the low bit `b`.
- R3: A symbol enable that finds a pending pair updates the encoded symbol 2*sym_hi+sym_lo to (2a+b + previous encoded symbol) mod 4. The new value is visible in the cycle after the enable.
- R4: The new low bit equals b XOR the previous low bit.
- R5: The new high bit equals a XOR the previous high bit XOR (b AND the previous low bit).
- R6: `sym_valid` is high for exactly one cycle, namely the cycle after each accepted symbol enable.
- R7: A symbol enable with no pending pair has no effect. The encoded bits hold their values and `sym_valid` stays low.
- R8: `chip_in` is ignored while `chip_en` is low.
- R9: A pair whose second chip arrives in the same cycle as a symbol enable is not used by that enable. It becomes pending for the next symbol enable.
- R10: When two pairs complete before a symbol enable, the later pair is the one that gets encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Qualifies `chip_in` for one chip |
| sym_en | input | 1 | Symbol-rate enable, half the chip rate |
| chip_in | input | 1 | Serial chip stream |
| sym_hi | output | 1 | Encoded high bit c |
| sym_lo | output | 1 | Encoded low bit d |
| sym_valid | output | 1 | One-cycle strobe for a new (c,d) |

## Verification
The hardest situations to reach are those where the pairing phase and the symbol enable drift apart. One case is a symbol enable that lands in the same cycle as the second chip of a pair. Another is a symbol enable that finds nothing new. A third is a reset that arrives halfway through a pair. The bench drives chip and symbol enables independently from tasks, so each of these alignments is placed deliberately. It then confirms through the encoded outputs which pair was used. A fixed vector table covers every carry combination. A long random stream is then compared against an integer modulo-4 accumulator.

// File: rtl/qde_pkg.sv
package qde_pkg;
  localparam int SYM_W = 2;
  typedef logic [SYM_W-1:0] qsym_t;

  function automatic qsym_t qde_advance(input qsym_t absv, input qsym_t prev);
    qsym_t nxt;
    nxt[0] = absv[0] ^ prev[0];
    nxt[1] = absv[1] ^ prev[1] ^ (absv[0] & prev[0]);
    return nxt;
  endfunction
endpackage

// File: rtl/qde_split.sv
module qde_split
  import qde_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  chip_en,
  input  logic  chip_in,
  input  logic  sym_en,
  output qsym_t pair_o,
  output logic  pend_o
);
  logic  half_q;
  logic  ibit_q;
  qsym_t pair_q;
  logic  pend_q;
  logic  pair_done;

  assign pair_done = chip_en & half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      ibit_q <= 1'b0;
      pair_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (chip_en) begin
        if (!half_q) begin
          ibit_q <= chip_in;
          half_q <= 1'b1;
        end else begin
          pair_q <= {ibit_q, chip_in};
          half_q <= 1'b0;
        end
      end
      pend_q <= pair_done | (pend_q & ~sym_en);
    end
  end

  assign pair_o = pair_q;
  assign pend_o = pend_q;

  assert_chip_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> $stable(pair_q) && $stable(half_q) && $stable(ibit_q));
  assert_late_pair_pending_R9: assert property (@(posedge clk) disable iff (rst)
    pair_done |=> pend_q);
  assert_pending_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    (sym_en && !pair_done) |=> !pend_q);
  assert_reset_phase_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !half_q && !pend_q);
endmodule

// File: rtl/qde_diff.sv
module qde_diff
  import qde_pkg::*;
#(
  parameter qsym_t INIT_SYM = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  qsym_t absv,
  output qsym_t sym_o,
  output logic  valid_o
);
  qsym_t sym_q;
  logic  valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q   <= INIT_SYM;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) sym_q <= qde_advance(absv, sym_q);
    end
  end

  assign sym_o   = sym_q;
  assign valid_o = valid_q;

  assert_mod4_sum_R3: assert property (@(posedge clk) disable iff (rst)
    take |=> sym_q == qsym_t'(($past(absv) + $past(sym_q)) % 4));
  assert_low_bit_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> sym_q[0] == ($past(absv[0]) ^ $past(sym_q[0])));
  assert_high_bit_R5: assert property (@(posedge clk) disable iff (rst)
    take |=> sym_q[1] == ($past(absv[1]) ^ $past(sym_q[1]) ^ ($past(absv[0]) & $past(sym_q[0]))));
  assert_hold_no_take_R7: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(sym_q) && !valid_q);
endmodule

// File: rtl/quad_diff_encoder.sv
module quad_diff_encoder
  import qde_pkg::*;
#(
  parameter logic [1:0] INIT_SYM = 2'b00
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_en,
  input  logic sym_en,
  input  logic chip_in,
  output logic sym_hi,
  output logic sym_lo,
  output logic sym_valid
);
  qsym_t pair;
  logic  pend;
  qsym_t enc;
  logic  vld;

  qde_split u_split (
    .clk(clk), .rst(rst), .chip_en(chip_en), .chip_in(chip_in),
    .sym_en(sym_en), .pair_o(pair), .pend_o(pend)
  );

  qde_diff #(.INIT_SYM(qsym_t'(INIT_SYM))) u_diff (
    .clk(clk), .rst(rst), .take(sym_en & pend), .absv(pair),
    .sym_o(enc), .valid_o(vld)
  );

  assign sym_hi    = enc[1];
  assign sym_lo    = enc[0];
  assign sym_valid = vld;

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);
  assert_valid_needs_pending_R6: assert property (@(posedge clk) disable iff (rst)
    (sym_en && pend) |=> sym_valid);
  assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sym_valid && sym_hi == INIT_SYM[1] && sym_lo == INIT_SYM[0]);
endmodule

// File: tb/test_quad_diff_encoder.sv
module test_quad_diff_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0;
  logic sym_en = 1'b0;
  logic chip_in = 1'b0;
  logic sym_hi, sym_lo, sym_valid;
  int checks = 0;
  int fails = 0;
  int acc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_diff_encoder i_quad_diff_encoder (
    .clk(clk), .rst(rst), .chip_en(chip_en), .sym_en(sym_en),
    .chip_in(chip_in), .sym_hi(sym_hi), .sym_lo(sym_lo), .sym_valid(sym_valid)
  );

  // {a, b, expected c, expected d}, starting from encoded symbol 00
  localparam logic [3:0] VEC [10] = '{
    4'b0000, 4'b0101, 4'b1011, 4'b1110, 4'b0111,
    4'b1110, 4'b1000, 4'b0000, 4'b1111, 4'b1110
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chip(input logic b);
    @(negedge clk);
    chip_en = 1'b1; chip_in = b;
    @(negedge clk);
    chip_en = 1'b0; chip_in = ~b;
  endtask

  task automatic pair(input logic a, input logic b);
    chip(a);
    chip(b);
  endtask

  // pulse sym_en, then sample the outputs one edge later and again on the next cycle
  task automatic sym(input bit exp_valid, input int exp_sym, input string req);
    int prev;
    prev = 2 * sym_hi + sym_lo;
    @(negedge clk);
    sym_en = 1'b1;
    @(negedge clk);
    sym_en = 1'b0;
    chk({req, " valid"}, sym_valid, exp_valid);
    chk({req, " symbol"}, 2 * sym_hi + sym_lo, exp_valid ? exp_sym : prev);
    @(negedge clk);
    chk("R6 strobe width", sym_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sym_hi", sym_hi, 0);
    chk("R1 reset sym_lo", sym_lo, 0);
    chk("R1 reset sym_valid", sym_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset valid", sym_valid, 0);

    // R2 R3 R4 R5: table of pairs covering every carry case
    for (int k = 0; k < 10; k++) begin
      pair(VEC[k][3], VEC[k][2]);
      sym(1'b1, VEC[k][1:0], "R3 R4 R5 table");
    end
    acc = 2;

    // R7: enable with nothing pending
    sym(1'b0, 0, "R7 no pending pair");

    // R8: chip_in toggling with chip_en low must not disturb pairing
    @(negedge clk); chip_in = 1'b1;
    @(negedge clk); chip_in = 1'b0;
    pair(1'b0, 1'b1);
    acc = (acc + 1) % 4;
    sym(1'b1, acc, "R8 ignored chips");

    // R9: second chip coincides with sym_en
    chip(1'b1);
    @(negedge clk);
    chip_en = 1'b1; chip_in = 1'b1; sym_en = 1'b1;
    @(negedge clk);
    chip_en = 1'b0; sym_en = 1'b0;
    chk("R9 same-cycle enable ignored", sym_valid, 0);
    acc = (acc + 3) % 4;
    sym(1'b1, acc, "R9 late pair used next");

    // R10: two pairs, the later wins
    pair(1'b1, 1'b0);
    pair(1'b0, 1'b1);
    acc = (acc + 1) % 4;
    sym(1'b1, acc, "R10 latest pair");

    // R1: reset in the middle of a pair realigns the split and clears the history
    chip(1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R1 mid-pair reset hi", sym_hi, 0);
    chk("R1 mid-pair reset lo", sym_lo, 0);
    sym(1'b0, 0, "R1 nothing pending after reset");
    pair(1'b0, 1'b1);
    acc = 1;
    sym(1'b1, acc, "R1 R2 realigned pair");

    // R3 R4 R5: random stream against integer accumulator and bit equations
    for (int n = 0; n < 300; n++) begin
      logic a, b, pc, pd;
      a = 1'($urandom);
      b = 1'($urandom);
      pc = sym_hi; pd = sym_lo;
      pair(a, b);
      acc = (acc + 2 * a + b) % 4;
      sym(1'b1, acc, "R3 random");
      chk("R4 low bit", sym_lo, b ^ pd);
      chk("R5 high bit", sym_hi, a ^ pc ^ (b & pd));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule